// File: doc/BRIEF.md
# Chained DMA Channel Controller

One channel of a peripheral-to-memory DMA engine. Software programs a control word and a set of 32-bit pointers through a word-wide register port. These are the working pointers next and limit, the reload pointers start and stop, and a one-shot initial-buffer pointer. When the attached device signals that a burst has arrived, the channel does the following:

- It rounds the burst length up to the channel's alignment granule.
- It selects a base address.
- It presents an address/length request to the memory port. The request is held until the port accepts it.

On acceptance the channel completes the transfer:

- It records the pointers that were used, as saved next and saved limit.
- It clears the initial-buffer pointer.
- Unless chaining-update is set, it reloads next and limit from start and stop.
- It raises its complete flag and pulses an interrupt for one cycle.

The parameter `NET_CHAN` selects a 32-byte granule instead of a 16-byte granule.

Top module: `dma_chain_chan`

## Requirements
- R1: After reset all pointer registers, saved pointers and status bits read zero, `mem_valid_o` is low and `irq_o` is low.
- R2: Writing the control word at offset 0x0 applies commands by bit. Bit 0 sets enable, bit 1 sets chaining-update, bit 2 clears complete and bit 4 sets direction (device to memory). A read of offset 0x0 returns status with enable in bit 0, chaining-update in bit 1, complete in bit 2, direction in bit 3 and zeros above.
- R3: Control bit 3 (channel reset) clears enable, chaining-update, complete and direction together. It overrides any set command in the same write.
- R4: Full 32-bit pointers are written and read back at these offsets: next at 0x4000, limit at 0x4004, start at 0x4008, stop at 0x400C and initial-buffer at 0x4200. Saved next reads at 0x4010 and saved limit at 0x4014. Both saved pointers are read-only.
- R5: A write to any other offset changes no register, and a read of any other offset returns zero.
- R6: The request length is the device length rounded up to a multiple of 16 bytes, or 32 bytes when `NET_CHAN` is 1. A length of zero stays zero.
- R7: The request address is the initial-buffer pointer if that is nonzero, otherwise next. It is sampled when the device completion is seen.
- R8: `mem_valid_o` rises in the cycle after `xfer_done_i`. It stays high with a stable address and length until a cycle with `mem_ready_i` high, and falls after that cycle.
- R9: At the accepting cycle, saved next takes next and saved limit takes next plus the rounded length.
- R10: At the accepting cycle, if chaining-update is clear, next is reloaded from start and limit from stop. If chaining-update is set, both keep their values.
- R11: The initial-buffer pointer reads zero after every accepted transfer.
- R12: The accepted transfer sets complete. `irq_o` is high for exactly the one cycle that follows the accepting cycle.
- R13: A `xfer_done_i` pulse while a request is pending is ignored. It alters neither the pending request nor creates a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 16 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the offset |
| xfer_done_i | input | 1 | Device burst complete, one-cycle strobe |
| xfer_len_i | input | 16 | Burst length in bytes, valid with xfer_done_i |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory request accepted |
| mem_addr_o | output | 32 | Request base address |
| mem_len_o | output | 17 | Request length in bytes, rounded |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
The bench checks rounding at the exact granule boundaries (0, 1, 16, 17 and the maximum length). An adder that is off by one would lose or add a whole granule there. It runs transfers with and without an initial-buffer pointer, and with and without chaining-update. A swapped base choice or an inverted reload condition shows up as wrong next, limit or saved values on the following read-back. It holds `mem_ready_i` low for several cycles and injects a second device strobe into that window. A design that updated early, reloaded the request or fired twice would move the address, pulse the interrupt out of turn or leave a stray request. Random pointer and command traffic is compared against a bench model after each transfer, including control writes that combine reset with set commands.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int unsigned REG_AW = 16;

  localparam logic [REG_AW-1:0] OFF_CTRL   = 16'h0000;
  localparam logic [REG_AW-1:0] OFF_NEXT   = 16'h4000;
  localparam logic [REG_AW-1:0] OFF_LIMIT  = 16'h4004;
  localparam logic [REG_AW-1:0] OFF_START  = 16'h4008;
  localparam logic [REG_AW-1:0] OFF_STOP   = 16'h400C;
  localparam logic [REG_AW-1:0] OFF_SNEXT  = 16'h4010;
  localparam logic [REG_AW-1:0] OFF_SLIMIT = 16'h4014;
  localparam logic [REG_AW-1:0] OFF_INIT   = 16'h4200;

  // command bits in a control write
  localparam int unsigned CMD_SET_EN    = 0;
  localparam int unsigned CMD_SET_CHAIN = 1;
  localparam int unsigned CMD_CLR_CMPL  = 2;
  localparam int unsigned CMD_RESET     = 3;
  localparam int unsigned CMD_DEV2MEM   = 4;

  // status word, en in bit 0
  typedef struct packed {
    logic dir;
    logic cmpl;
    logic chain;
    logic en;
  } chan_stat_t;

  typedef enum logic {XF_IDLE, XF_REQ} xfer_state_e;
endpackage

// File: rtl/dma_chain_xfer.sv
module dma_chain_xfer #(
  parameter int unsigned DW       = 32,
  parameter int unsigned LEN_W    = 16,
  parameter bit          NET_CHAN = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [DW-1:0]    next_i,
  input  logic [DW-1:0]    init_i,
  input  logic             mem_ready_i,
  output logic             mem_valid_o,
  output logic [DW-1:0]    mem_addr_o,
  output logic [LEN_W:0]   mem_len_o,
  output logic             cmpl_o
);
  import dma_chain_pkg::*;

  localparam int unsigned ALG   = NET_CHAN ? 5 : 4;
  localparam int unsigned ALIGN = 1 << ALG;

  xfer_state_e      state_q;
  logic [DW-1:0]    addr_q;
  logic [LEN_W:0]   len_q;
  logic [LEN_W:0]   sum;
  logic [LEN_W:0]   rnd;
  logic [DW-1:0]    base;

  assign sum  = {1'b0, len_i} + (LEN_W+1)'(ALIGN - 1);
  assign rnd  = {sum[LEN_W:ALG], {ALG{1'b0}}};
  assign base = (init_i != '0) ? init_i : next_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XF_IDLE;
      addr_q  <= '0;
      len_q   <= '0;
    end else begin
      unique case (state_q)
        XF_IDLE: if (start_i) begin
          state_q <= XF_REQ;
          addr_q  <= base;
          len_q   <= rnd;
        end
        XF_REQ: if (mem_ready_i) state_q <= XF_IDLE;
        default: state_q <= XF_IDLE;
      endcase
    end
  end

  assign mem_valid_o = (state_q == XF_REQ);
  assign mem_addr_o  = addr_q;
  assign mem_len_o   = len_q;
  assign cmpl_o      = mem_valid_o && mem_ready_i;
endmodule

// File: rtl/dma_chain_regs.sv
module dma_chain_regs #(
  parameter int unsigned DW    = 32,
  parameter int unsigned LEN_W = 16
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              reg_req_i,
  input  logic                              reg_we_i,
  input  logic [dma_chain_pkg::REG_AW-1:0]  reg_addr_i,
  input  logic [DW-1:0]                     reg_wdata_i,
  output logic [DW-1:0]                     reg_rdata_o,
  input  logic                              cmpl_i,
  input  logic [LEN_W:0]                    cmpl_len_i,
  output logic [DW-1:0]                     next_o,
  output logic [DW-1:0]                     init_o,
  output logic                              irq_o
);
  import dma_chain_pkg::*;

  chan_stat_t    stat_q, stat_d;
  logic [DW-1:0] next_q, limit_q, start_q, stop_q, init_q, snext_q, slimit_q;
  logic          irq_q;
  logic          wr;
  logic          wr_ctrl, wr_next, wr_limit, wr_start, wr_stop, wr_init;

  assign wr       = reg_req_i && reg_we_i;
  assign wr_ctrl  = wr && (reg_addr_i == OFF_CTRL);
  assign wr_next  = wr && (reg_addr_i == OFF_NEXT);
  assign wr_limit = wr && (reg_addr_i == OFF_LIMIT);
  assign wr_start = wr && (reg_addr_i == OFF_START);
  assign wr_stop  = wr && (reg_addr_i == OFF_STOP);
  assign wr_init  = wr && (reg_addr_i == OFF_INIT);

  always_comb begin
    stat_d = stat_q;
    if (wr_ctrl) begin
      if (reg_wdata_i[CMD_SET_EN])    stat_d.en    = 1'b1;
      if (reg_wdata_i[CMD_SET_CHAIN]) stat_d.chain = 1'b1;
      if (reg_wdata_i[CMD_CLR_CMPL])  stat_d.cmpl  = 1'b0;
      if (reg_wdata_i[CMD_DEV2MEM])   stat_d.dir   = 1'b1;
      if (reg_wdata_i[CMD_RESET])     stat_d       = '0;
    end
    if (cmpl_i) stat_d.cmpl = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q   <= '0;
      next_q   <= '0;
      limit_q  <= '0;
      start_q  <= '0;
      stop_q   <= '0;
      init_q   <= '0;
      snext_q  <= '0;
      slimit_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= cmpl_i;
      if (wr_start) start_q <= reg_wdata_i;
      if (wr_stop)  stop_q  <= reg_wdata_i;
      // completion wins over a same-cycle software write
      if (cmpl_i && !stat_q.chain) begin
        next_q  <= start_q;
        limit_q <= stop_q;
      end else begin
        if (wr_next)  next_q  <= reg_wdata_i;
        if (wr_limit) limit_q <= reg_wdata_i;
      end
      if (cmpl_i) begin
        snext_q  <= next_q;
        slimit_q <= next_q + DW'(cmpl_len_i);
        init_q   <= '0;
      end else if (wr_init) begin
        init_q <= reg_wdata_i;
      end
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      OFF_CTRL:   reg_rdata_o = DW'(stat_q);
      OFF_NEXT:   reg_rdata_o = next_q;
      OFF_LIMIT:  reg_rdata_o = limit_q;
      OFF_START:  reg_rdata_o = start_q;
      OFF_STOP:   reg_rdata_o = stop_q;
      OFF_SNEXT:  reg_rdata_o = snext_q;
      OFF_SLIMIT: reg_rdata_o = slimit_q;
      OFF_INIT:   reg_rdata_o = init_q;
      default:    reg_rdata_o = '0;
    endcase
  end

  assign next_o = next_q;
  assign init_o = init_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan #(
  parameter int unsigned DW       = 32,
  parameter int unsigned LEN_W    = 16,
  parameter bit          NET_CHAN = 1'b0
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              reg_req_i,
  input  logic                              reg_we_i,
  input  logic [dma_chain_pkg::REG_AW-1:0]  reg_addr_i,
  input  logic [DW-1:0]                     reg_wdata_i,
  output logic [DW-1:0]                     reg_rdata_o,
  input  logic                              xfer_done_i,
  input  logic [LEN_W-1:0]                  xfer_len_i,
  output logic                              mem_valid_o,
  input  logic                              mem_ready_i,
  output logic [DW-1:0]                     mem_addr_o,
  output logic [LEN_W:0]                    mem_len_o,
  output logic                              irq_o
);
  logic [DW-1:0] next_w;
  logic [DW-1:0] init_w;
  logic          cmpl_w;

  dma_chain_xfer #(.DW(DW), .LEN_W(LEN_W), .NET_CHAN(NET_CHAN)) u_xfer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (xfer_done_i),
    .len_i       (xfer_len_i),
    .next_i      (next_w),
    .init_i      (init_w),
    .mem_ready_i (mem_ready_i),
    .mem_valid_o (mem_valid_o),
    .mem_addr_o  (mem_addr_o),
    .mem_len_o   (mem_len_o),
    .cmpl_o      (cmpl_w)
  );

  dma_chain_regs #(.DW(DW), .LEN_W(LEN_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_req_i   (reg_req_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .cmpl_i      (cmpl_w),
    .cmpl_len_i  (mem_len_o),
    .next_o      (next_w),
    .init_o      (init_w),
    .irq_o       (irq_o)
  );
endmodule

// File: rtl/dma_chain_chan_chk.sv
module dma_chain_chan_chk #(
  parameter int unsigned DW       = 32,
  parameter int unsigned LEN_W    = 16,
  parameter bit          NET_CHAN = 1'b0
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           mem_valid_o,
  input logic           mem_ready_i,
  input logic [DW-1:0]  mem_addr_o,
  input logic [LEN_W:0] mem_len_o,
  input logic           irq_o,
  input logic [DW-1:0]  init_w
);
  localparam int unsigned ALG = NET_CHAN ? 5 : 4;

  p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_len_o));

  p_req_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && mem_ready_i |=> !mem_valid_o);

  p_len_align_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (mem_len_o[ALG-1:0] == '0));

  p_irq_follows_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && mem_ready_i |=> irq_o);

  p_irq_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_init_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && mem_ready_i |=> init_w == '0);
endmodule

bind dma_chain_chan dma_chain_chan_chk #(.DW(DW), .LEN_W(LEN_W), .NET_CHAN(NET_CHAN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_valid_o (mem_valid_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .mem_len_o   (mem_len_o),
  .irq_o       (irq_o),
  .init_w      (init_w)
);

// File: tb/tb_dma_chain_chan.sv
module tb_dma_chain_chan;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_req_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [15:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        xfer_done_i = 1'b0;
  logic [15:0] xfer_len_i = '0;
  logic        mem_valid_o;
  logic        mem_ready_i = 1'b0;
  logic [31:0] mem_addr_o;
  logic [16:0] mem_len_o;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;

  // bench model
  logic [31:0] m_next, m_limit, m_start, m_stop, m_init, m_snext, m_slimit;
  logic        m_en, m_chain, m_cmpl, m_dir;

  dma_chain_chan dut (.*);

  always #10 clk_i = ~clk_i;

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic logic [16:0] f_round(input logic [15:0] len);
    logic [16:0] s;
    s = {1'b0, len} + 17'd15;
    return {s[16:4], 4'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_req_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_req_i = 1'b0; reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_req_i = 1'b1; reg_we_i = 1'b0; reg_addr_i = a;
    #1 d = reg_rdata_o;
    reg_req_i = 1'b0;
  endtask

  task automatic ctrl(input logic [31:0] w);
    wr(16'h0000, w);
    if (w[0]) m_en = 1'b1;
    if (w[1]) m_chain = 1'b1;
    if (w[2]) m_cmpl = 1'b0;
    if (w[4]) m_dir = 1'b1;
    if (w[3]) begin m_en = 0; m_chain = 0; m_cmpl = 0; m_dir = 0; end
  endtask

  task automatic set_ptrs(input logic [31:0] n, l, s, t, i);
    wr(16'h4000, n); m_next = n;
    wr(16'h4004, l); m_limit = l;
    wr(16'h4008, s); m_start = s;
    wr(16'h400C, t); m_stop = t;
    wr(16'h4200, i); m_init = i;
  endtask

  task automatic check_all(input string req);
    logic [31:0] d;
    rd(16'h0000, d); chk({req, " status R2"}, d, {28'b0, m_dir, m_cmpl, m_chain, m_en});
    rd(16'h4000, d); chk({req, " next R10"}, d, m_next);
    rd(16'h4004, d); chk({req, " limit R10"}, d, m_limit);
    rd(16'h4008, d); chk({req, " start R4"}, d, m_start);
    rd(16'h400C, d); chk({req, " stop R4"}, d, m_stop);
    rd(16'h4200, d); chk({req, " init R11"}, d, m_init);
    rd(16'h4010, d); chk({req, " saved next R9"}, d, m_snext);
    rd(16'h4014, d); chk({req, " saved limit R9"}, d, m_slimit);
  endtask

  task automatic xfer(input logic [15:0] len, input int delay, input bit inject);
    logic [31:0] base;
    logic [16:0] rl;
    @(negedge clk_i);
    xfer_done_i = 1'b1; xfer_len_i = len;
    base = (m_init != 0) ? m_init : m_next;
    rl = f_round(len);
    @(negedge clk_i);
    xfer_done_i = 1'b0;
    chk("R8 valid rise", {31'b0, mem_valid_o}, 32'd1);
    chk("R7 base", mem_addr_o, base);
    chk("R6 length", {15'b0, mem_len_o}, {15'b0, rl});
    for (int k = 0; k < delay; k++) begin
      if (inject && k == 0) begin xfer_done_i = 1'b1; xfer_len_i = ~len; end
      @(negedge clk_i);
      xfer_done_i = 1'b0;
      chk("R8 hold valid", {31'b0, mem_valid_o}, 32'd1);
      chk("R13 addr held", mem_addr_o, base);
      chk("R13 len held", {15'b0, mem_len_o}, {15'b0, rl});
      chk("R12 no early irq", {31'b0, irq_o}, 32'd0);
    end
    mem_ready_i = 1'b1;
    @(negedge clk_i);
    mem_ready_i = 1'b0;
    chk("R8 valid fall", {31'b0, mem_valid_o}, 32'd0);
    chk("R12 irq pulse", {31'b0, irq_o}, 32'd1);
    m_snext = m_next;
    m_slimit = m_next + {15'b0, rl};
    m_init = '0;
    if (!m_chain) begin m_next = m_start; m_limit = m_stop; end
    m_cmpl = 1'b1;
    @(negedge clk_i);
    chk("R12 irq one cycle", {31'b0, irq_o}, 32'd0);
    chk("R13 no second req", {31'b0, mem_valid_o}, 32'd0);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    m_next = 0; m_limit = 0; m_start = 0; m_stop = 0; m_init = 0;
    m_snext = 0; m_slimit = 0;
    m_en = 0; m_chain = 0; m_cmpl = 0; m_dir = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 valid", {31'b0, mem_valid_o}, 32'd0);
    chk("R1 irq", {31'b0, irq_o}, 32'd0);
    check_all("R1 reset");

    // R4 pointer readback
    set_ptrs(32'h1000_0000, 32'h1000_0100, 32'h2000_0000, 32'h2000_0800, 32'h0);
    check_all("R4 readback");

    // R5 unmapped
    wr(16'h4100, 32'hDEAD_BEEF);
    wr(16'h0004, 32'hFFFF_FFFF);
    rd(16'h4100, d); chk("R5 unmapped read", d, 32'h0);
    rd(16'h4018, d); chk("R5 unmapped read 2", d, 32'h0);
    check_all("R5 no effect");

    // R2 / R3 commands
    ctrl(32'h1);  check_all("R2 set en");
    ctrl(32'h10); check_all("R2 set dir");
    ctrl(32'h2);  check_all("R2 set chain");
    ctrl(32'h1B); check_all("R3 reset wins");

    // R6 boundaries, chain clear -> R10 reload
    xfer(16'd0, 0, 0);     check_all("R6 len0");
    xfer(16'd1, 1, 0);     check_all("R6 len1");
    ctrl(32'h4);           check_all("R2 clr cmpl");
    xfer(16'd16, 0, 0);    check_all("R6 len16");
    xfer(16'd17, 2, 0);    check_all("R6 len17");
    xfer(16'hFFFF, 0, 0);  check_all("R6 lenmax");

    // R7 init buffer override, R11 cleared
    set_ptrs(32'h3000_0040, 32'h3000_1000, 32'h4000_0000, 32'h4000_0200, 32'h5000_0000);
    xfer(16'd40, 1, 0);    check_all("R7 init used");
    xfer(16'd40, 0, 0);    check_all("R7 next used");

    // R10 chaining set keeps pointers; R13 injected strobe
    ctrl(32'h2);
    set_ptrs(32'h6000_0000, 32'h6000_0400, 32'h7000_0000, 32'h7000_0400, 32'h0);
    xfer(16'd100, 3, 1);   check_all("R10 chain keep R13");

    // random traffic
    for (int it = 0; it < 60; it++) begin
      if ($urandom_range(0, 1) == 1)
        set_ptrs($urandom, $urandom, $urandom, $urandom,
                 ($urandom_range(0, 2) == 0) ? 32'h0 : $urandom);
      ctrl({27'b0, 5'($urandom)});
      xfer(16'($urandom), $urandom_range(0, 3), $urandom_range(0, 3) == 0);
      check_all("rand R9 R10");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule